// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block holds a small, fully associative table of segment entries. Each entry pairs an effective-segment word with a virtual-segment word. The effective-segment word holds the segment number and a valid flag. The virtual-segment word holds a segment-size field, protection keys and a page-size selector. A translation port takes an effective address and, one cycle later, reports whether a segment entry covers it, which entry that is and that entry's virtual-segment word. Each entry compares against the address at one of two granularities, 256 MB or 1 TB, chosen by its own size field.

Software maintains the table through a request port with a valid/ready handshake. Seven operations are available: write an entry, read either word of a slot, find the virtual-segment word for an address, invalidate by address (local or global form) and invalidate all. The result appears one cycle after acceptance, with an error flag for operations that fail. Invalidations raise a one-cycle flush request toward a downstream translation cache. Writes are checked against a parameterised table of legal page-size encodings, and 1 TB segments can be disabled by a configuration input.

Control is a two-state machine. In ST_IDLE the block accepts a request (transition ACCEPT to ST_RESP). In ST_RESP it presents the result for one cycle and then returns unconditionally (transition RETIRE to ST_IDLE).

Top module: `seg_lookaside_array`

## Requirements
- R1: After reset every entry word is zero. op_ready is 1. rsp_valid, flush_local and flush_global are 0. Lookups miss and slot reads return 0.
- R2: A request is accepted on a clock edge where op_valid and op_ready are both 1. rsp_valid is then 1 for exactly the next cycle, and op_ready is 0 during that cycle.
- R3: The lookup port forms two keys from lk_addr, each with bit 27 (valid) set. The 256 MB key is address bits 63:28 with bits 26:0 zero. The 1 TB key is address bits 63:40 with bits 39:28 and 26:0 zero. An entry hits if it equals the 256 MB key and its size field (VSID bits 63:62) is 00, or if it equals the 1 TB key and its size field is 01. The result appears one cycle after lk_valid with lk_rsp_valid. On a miss, lk_idx and lk_vsid are 0.
- R4: When several entries hit, the lowest index wins. This applies to lookups, find and invalidate-by-address alike.
- R5: Write (op code 0) takes the slot from op_arg_b bits 11:0, the effective-segment word from op_arg_b with bits 11:0 cleared, and the virtual-segment word from op_arg_s.
- R6: A write is rejected with rsp_err=1 and leaves the table unchanged if any of these hold: the slot is not below NUM_ENT; any of op_arg_b bits 26:12 is set; op_arg_s bit 63 is set.
- R7: A write is also rejected if op_arg_s bit 62 (1 TB) is set while cfg_ena_1t is 0. It is rejected too if op_arg_s bits {8,5,4} (mask 0x130) match none of PS_ENC, which defaults to 0x000, 0x100 and 0x110.
- R8: Read effective word (code 1) and read virtual word (code 2) use op_arg_b bits 11:0 as the slot. An out-of-range slot gives rsp_err=1 with data 0.
- R9: Find (code 3) returns the hitting entry's virtual-segment word, or all ones on a miss, never with an error. When cfg_mode32 is 1, address bits 63:32 are treated as zero.
- R10: Invalidate-by-address clears bit 27 of the hitting entry. Code 4 raises flush_local and code 5 raises flush_global, each together with rsp_valid. A miss changes nothing and raises no flush.
- R11: Invalidate-all (code 6) clears bit 27 in entries 1 to NUM_ENT-1 and leaves entry 0 untouched. It raises flush_local only if at least one of those entries had bit 27 set.
- R12: Op code 7 gives rsp_err=1 and changes nothing.
- R13: A lookup requested in the same cycle that a software operation is accepted sees the table as it was before that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ena_1t | input | 1 | Permit 1 TB segment writes |
| cfg_mode32 | input | 1 | Core in 32-bit mode (find masks the address) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Lookup effective address |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDXW | Index of hitting entry |
| lk_vsid | output | 64 | Virtual-segment word of hitting entry |
| op_valid | input | 1 | Software request valid |
| op_ready | output | 1 | Block can accept a request |
| op_code | input | 3 | Operation code |
| op_arg_b | input | 64 | Slot/address operand |
| op_arg_s | input | 64 | Virtual-segment word for writes |
| rsp_valid | output | 1 | Software result valid |
| rsp_err | output | 1 | Operation failed |
| rsp_data | output | 64 | Read or find result |
| flush_local | output | 1 | Local flush request |
| flush_global | output | 1 | Global flush request |

## Verification
The translation port and the software port are independent, so a lookup can fall in the same cycle that a write or invalidation is accepted. The bench provokes this by raising lk_valid in the same cycle as an accepted write to the very segment being looked up, and again alongside an invalidation of a hitting entry. It judges the lookup against a reference model sampled before that operation is applied. A follow-up lookup then confirms the new contents, so both the old-table result and the update are seen.

// File: rtl/slb_pkg.sv
package slb_pkg;
    localparam int WORD_W      = 64;
    localparam int VBIT        = 27;
    localparam int SEG256_LSB  = 28;
    localparam int SEG1T_LSB   = 40;
    localparam int SLOT_BITS   = 12;
    localparam int SZ_HI       = 63;
    localparam int SZ_LO       = 62;
    localparam logic [1:0]  SZ_256M = 2'b00;
    localparam logic [1:0]  SZ_1T   = 2'b01;
    localparam logic [11:0] PS_MASK = 12'h130;

    typedef enum logic [2:0] {
        OP_WRITE   = 3'd0,
        OP_RD_ESID = 3'd1,
        OP_RD_VSID = 3'd2,
        OP_FIND    = 3'd3,
        OP_INV     = 3'd4,
        OP_INV_GLB = 3'd5,
        OP_INV_ALL = 3'd6,
        OP_BAD     = 3'd7
    } sop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } st_e;
endpackage

// File: rtl/slb_match.sv
module slb_match
    import slb_pkg::*;
#(
    parameter int NUM_ENT = 32,
    parameter int IDXW    = 5
) (
    input  logic [WORD_W-1:0]              addr,
    input  logic [NUM_ENT-1:0][WORD_W-1:0] esid_tab,
    input  logic [NUM_ENT-1:0][WORD_W-1:0] vsid_tab,
    output logic                           hit,
    output logic [IDXW-1:0]                idx,
    output logic [WORD_W-1:0]              vsid
);
    localparam int GAP_1T = SEG1T_LSB - SEG256_LSB;

    logic [WORD_W-1:0]  key_256m;
    logic [WORD_W-1:0]  key_1t;
    logic [NUM_ENT-1:0] m;

    assign key_256m = {addr[WORD_W-1:SEG256_LSB], 1'b1, {VBIT{1'b0}}};
    assign key_1t   = {addr[WORD_W-1:SEG1T_LSB], {GAP_1T{1'b0}}, 1'b1, {VBIT{1'b0}}};

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign m[g] = ((esid_tab[g] == key_256m) && (vsid_tab[g][SZ_HI:SZ_LO] == SZ_256M))
                   || ((esid_tab[g] == key_1t)   && (vsid_tab[g][SZ_HI:SZ_LO] == SZ_1T));
    end

    always_comb begin
        hit  = |m;
        idx  = '0;
        vsid = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (m[i]) begin
                idx  = IDXW'(i);
                vsid = vsid_tab[i];
            end
        end
    end
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check
    import slb_pkg::*;
#(
    parameter int                         NUM_ENT = 32,
    parameter int                         NUM_PS  = 3,
    parameter logic [NUM_PS-1:0][11:0]    PS_ENC  = {12'h110, 12'h100, 12'h000}
) (
    input  logic [WORD_W-1:0] arg_b,
    input  logic [WORD_W-1:0] arg_s,
    input  logic              ena_1t,
    output logic              ok
);
    logic [NUM_PS-1:0] ps_hit;
    logic              slot_ok;
    logic              rsv_clear;
    logic              size_ok;

    for (genvar p = 0; p < NUM_PS; p++) begin : g_ps
        assign ps_hit[p] = ((arg_s[11:0] & PS_MASK) == PS_ENC[p]);
    end

    assign slot_ok   = {1'b0, arg_b[SLOT_BITS-1:0]} < (SLOT_BITS+1)'(NUM_ENT);
    assign rsv_clear = (arg_b[VBIT-1:SLOT_BITS] == '0);
    assign size_ok   = !arg_s[SZ_HI] && (!arg_s[SZ_LO] || ena_1t);
    assign ok        = slot_ok && rsv_clear && size_ok && (|ps_hit);
endmodule

// File: rtl/seg_lookaside_array.sv
module seg_lookaside_array
    import slb_pkg::*;
#(
    parameter int                      NUM_ENT = 32,
    parameter int                      NUM_PS  = 3,
    parameter logic [NUM_PS-1:0][11:0] PS_ENC  = {12'h110, 12'h100, 12'h000},
    localparam int                     IDXW    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ena_1t,
    input  logic              cfg_mode32,
    input  logic              lk_valid,
    input  logic [63:0]       lk_addr,
    output logic              lk_rsp_valid,
    output logic              lk_hit,
    output logic [IDXW-1:0]   lk_idx,
    output logic [63:0]       lk_vsid,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [2:0]        op_code,
    input  logic [63:0]       op_arg_b,
    input  logic [63:0]       op_arg_s,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_data,
    output logic              flush_local,
    output logic              flush_global
);
    st_e state_q, state_d;

    logic [NUM_ENT-1:0][WORD_W-1:0] esid_q;
    logic [NUM_ENT-1:0][WORD_W-1:0] vsid_q;

    sop_e                op;
    logic                accept;
    logic [SLOT_BITS-1:0] slot_raw;
    logic                slot_ok;
    logic [IDXW-1:0]     slot;
    logic [WORD_W-1:0]   sw_addr;

    logic                lk_hit_c, sw_hit;
    logic [IDXW-1:0]     lk_idx_c, sw_idx;
    logic [WORD_W-1:0]   lk_vsid_c, sw_vsid;
    logic                wr_ok;
    logic                any_rest;

    logic                err_d, fl_d, fg_d, wr_en, inv_hit_en, inv_all_en;
    logic [WORD_W-1:0]   data_d;
    logic                err_q, fl_q, fg_q;
    logic [WORD_W-1:0]   data_q;

    assign op       = sop_e'(op_code);
    assign accept   = op_valid && op_ready;
    assign slot_raw = op_arg_b[SLOT_BITS-1:0];
    assign slot_ok  = {1'b0, slot_raw} < (SLOT_BITS+1)'(NUM_ENT);
    assign slot     = slot_raw[IDXW-1:0];
    assign sw_addr  = (op == OP_FIND && cfg_mode32) ? {32'h0, op_arg_b[31:0]} : op_arg_b;

    slb_match #(.NUM_ENT(NUM_ENT), .IDXW(IDXW)) u_lk_match (
        .addr(lk_addr), .esid_tab(esid_q), .vsid_tab(vsid_q),
        .hit(lk_hit_c), .idx(lk_idx_c), .vsid(lk_vsid_c)
    );

    slb_match #(.NUM_ENT(NUM_ENT), .IDXW(IDXW)) u_sw_match (
        .addr(sw_addr), .esid_tab(esid_q), .vsid_tab(vsid_q),
        .hit(sw_hit), .idx(sw_idx), .vsid(sw_vsid)
    );

    slb_wr_check #(.NUM_ENT(NUM_ENT), .NUM_PS(NUM_PS), .PS_ENC(PS_ENC)) u_wr_check (
        .arg_b(op_arg_b), .arg_s(op_arg_s), .ena_1t(cfg_ena_1t), .ok(wr_ok)
    );

    always_comb begin
        any_rest = 1'b0;
        for (int i = 1; i < NUM_ENT; i++) begin
            any_rest = any_rest | esid_q[i][VBIT];
        end
    end

    // operation decode
    always_comb begin
        err_d      = 1'b0;
        data_d     = '0;
        fl_d       = 1'b0;
        fg_d       = 1'b0;
        wr_en      = 1'b0;
        inv_hit_en = 1'b0;
        inv_all_en = 1'b0;
        unique case (op)
            OP_WRITE: begin
                if (wr_ok) wr_en = 1'b1;
                else       err_d = 1'b1;
            end
            OP_RD_ESID: begin
                if (slot_ok) data_d = esid_q[slot];
                else         err_d  = 1'b1;
            end
            OP_RD_VSID: begin
                if (slot_ok) data_d = vsid_q[slot];
                else         err_d  = 1'b1;
            end
            OP_FIND: begin
                data_d = sw_hit ? sw_vsid : '1;
            end
            OP_INV: begin
                inv_hit_en = sw_hit;
                fl_d       = sw_hit;
            end
            OP_INV_GLB: begin
                inv_hit_en = sw_hit;
                fg_d       = sw_hit;
            end
            OP_INV_ALL: begin
                inv_all_en = 1'b1;
                fl_d       = any_rest;
            end
            OP_BAD: begin
                err_d = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        op_ready     = (state_q == ST_IDLE);
        rsp_valid    = (state_q == ST_RESP);
        rsp_err      = rsp_valid && err_q;
        rsp_data     = rsp_valid ? data_q : '0;
        flush_local  = rsp_valid && fl_q;
        flush_global = rsp_valid && fg_q;
    end

    // table storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esid_q <= '0;
            vsid_q <= '0;
        end else if (accept) begin
            if (wr_en) begin
                esid_q[slot] <= {op_arg_b[WORD_W-1:SLOT_BITS], {SLOT_BITS{1'b0}}};
                vsid_q[slot] <= op_arg_s;
            end
            if (inv_hit_en) esid_q[sw_idx][VBIT] <= 1'b0;
            if (inv_all_en) begin
                for (int i = 1; i < NUM_ENT; i++) esid_q[i][VBIT] <= 1'b0;
            end
        end
    end

    // response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            fl_q   <= 1'b0;
            fg_q   <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            err_q  <= err_d;
            fl_q   <= fl_d;
            fg_q   <= fg_d;
            data_q <= data_d;
        end
    end

    // lookup result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rsp_valid <= 1'b0;
            lk_hit       <= 1'b0;
            lk_idx       <= '0;
            lk_vsid      <= '0;
        end else begin
            lk_rsp_valid <= lk_valid;
            if (lk_valid) begin
                lk_hit  <= lk_hit_c;
                lk_idx  <= lk_idx_c;
                lk_vsid <= lk_vsid_c;
            end
        end
    end

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> rsp_valid); // R2
    AST_NO_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !op_ready); // R2
    AST_LK_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid |-> $past(lk_valid)); // R3
    AST_LK_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp_valid && !lk_hit) |-> (lk_idx == '0 && lk_vsid == '0)); // R3
    AST_ERR_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (esid_q == $past(esid_q) && vsid_q == $past(vsid_q))); // R6
    AST_FLUSH_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_local || flush_global) |-> (rsp_valid && !(flush_local && flush_global))); // R10
    AST_ENTRY0_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_code == OP_INV_ALL) |=> (esid_q[0] == $past(esid_q[0]))); // R11
endmodule

// File: tb/test_seg_lookaside_array.sv
`timescale 1ns/1ps
module test_seg_lookaside_array;
    localparam int N  = 32;
    localparam int IW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ena_1t = 1'b0, cfg_mode32 = 1'b0;
    logic lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic lk_rsp_valid, lk_hit;
    logic [IW-1:0] lk_idx;
    logic [63:0] lk_vsid;
    logic op_valid = 1'b0;
    logic op_ready;
    logic [2:0] op_code = '0;
    logic [63:0] op_arg_b = '0, op_arg_s = '0;
    logic rsp_valid, rsp_err, flush_local, flush_global;
    logic [63:0] rsp_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] m_esid [N];
    logic [63:0] m_vsid [N];

    always #2.5 clk = ~clk;

    seg_lookaside_array i_seg_lookaside_array (
        .clk(clk), .rst_n(rst_n), .cfg_ena_1t(cfg_ena_1t), .cfg_mode32(cfg_mode32),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_rsp_valid(lk_rsp_valid),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_vsid(lk_vsid),
        .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
        .op_arg_b(op_arg_b), .op_arg_s(op_arg_s), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data),
        .flush_local(flush_local), .flush_global(flush_global)
    );

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    // reference: first entry whose segment covers the address
    function automatic int m_find(logic [63:0] a);
        for (int i = 0; i < N; i++) begin
            if (m_esid[i][27]) begin
                if (m_vsid[i][63:62] == 2'b00 && m_esid[i][63:28] == a[63:28] && m_esid[i][26:0] == 0)
                    return i;
                if (m_vsid[i][63:62] == 2'b01 && m_esid[i][63:40] == a[63:40]
                    && m_esid[i][39:28] == 0 && m_esid[i][26:0] == 0)
                    return i;
            end
        end
        return -1;
    endfunction

    task automatic lookup(logic [63:0] a, string rq);
        int h;
        h = m_find(a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rq, {63'h0, lk_rsp_valid}, 64'h1);
        chk(rq, {63'h0, lk_hit}, (h >= 0) ? 64'h1 : 64'h0);
        chk(rq, {59'h0, lk_idx}, (h >= 0) ? 64'(h) : 64'h0);
        chk(rq, lk_vsid, (h >= 0) ? m_vsid[h] : 64'h0);
    endtask

    task automatic run(logic [2:0] code, logic [63:0] b, logic [63:0] s,
                       bit lk_en, logic [63:0] lk_a, string rq);
        logic e_err = 1'b0, e_fl = 1'b0, e_fg = 1'b0;
        logic [63:0] e_data = '0;
        logic [63:0] es, a;
        logic [11:0] ps;
        int lh, h, slot;
        logic [63:0] e_lvs;
        lh = m_find(lk_a);
        e_lvs = (lh >= 0) ? m_vsid[lh] : 64'h0;
        slot = int'(b[11:0]);
        case (code)
            3'd0: begin
                es = {b[63:12], 12'h0};
                ps = s[11:0] & 12'h130;
                if (slot >= N || es[26:12] != 0 || s[63] || (s[62] && !cfg_ena_1t)
                    || !(ps == 12'h000 || ps == 12'h100 || ps == 12'h110))
                    e_err = 1'b1;
                else begin
                    m_esid[slot] = es;
                    m_vsid[slot] = s;
                end
            end
            3'd1, 3'd2: begin
                if (slot >= N) e_err = 1'b1;
                else e_data = (code == 3'd1) ? m_esid[slot] : m_vsid[slot];
            end
            3'd3: begin
                a = cfg_mode32 ? {32'h0, b[31:0]} : b;
                h = m_find(a);
                e_data = (h < 0) ? '1 : m_vsid[h];
            end
            3'd4, 3'd5: begin
                h = m_find(b);
                if (h >= 0) begin
                    m_esid[h][27] = 1'b0;
                    if (code == 3'd4) e_fl = 1'b1; else e_fg = 1'b1;
                end
            end
            3'd6: begin
                for (int i = 1; i < N; i++) begin
                    if (m_esid[i][27]) begin
                        m_esid[i][27] = 1'b0;
                        e_fl = 1'b1;
                    end
                end
            end
            default: e_err = 1'b1;
        endcase
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_arg_b = b; op_arg_s = s;
        lk_valid = lk_en; lk_addr = lk_a;
        @(negedge clk);
        op_valid = 1'b0; lk_valid = 1'b0;
        chk({rq, " R2 rsp_valid"}, {63'h0, rsp_valid}, 64'h1);
        chk({rq, " R2 ready low"}, {63'h0, op_ready}, 64'h0);
        chk({rq, " err"}, {63'h0, rsp_err}, {63'h0, e_err});
        chk({rq, " data"}, rsp_data, e_data);
        chk({rq, " flush_local"}, {63'h0, flush_local}, {63'h0, e_fl});
        chk({rq, " flush_global"}, {63'h0, flush_global}, {63'h0, e_fg});
        if (lk_en) begin
            chk({rq, " R13 lk_hit"}, {63'h0, lk_hit}, (lh >= 0) ? 64'h1 : 64'h0);
            chk({rq, " R13 lk_idx"}, {59'h0, lk_idx}, (lh >= 0) ? 64'(lh) : 64'h0);
            chk({rq, " R13 lk_vsid"}, lk_vsid, e_lvs);
        end
        @(negedge clk);
        chk({rq, " R2 retire"}, {62'h0, rsp_valid, op_ready}, 64'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R2 watchdog actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_esid[i] = '0;
            m_vsid[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {63'h0, op_ready}, 64'h1);
        chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
        chk("R1 flush", {62'h0, flush_local, flush_global}, 64'h0);
        lookup(64'h0000_0012_3456_7890, "R1 lookup miss");
        run(3'd1, 64'h5, 64'h0, 1'b0, 64'h0, "R1 read esid 5");
        run(3'd2, 64'h5, 64'h0, 1'b0, 64'h0, "R1 read vsid 5");

        // R5 write 256MB entry, R3 lookup, R8 reads
        run(3'd0, 64'h0000_0012_3800_0003, 64'h0000_0000_ABCD_0110, 1'b0, 64'h0, "R5 write slot3");
        lookup(64'h0000_0012_3456_7890, "R3 hit 256M");
        lookup(64'h0000_0012_4456_7890, "R3 miss neighbour");
        run(3'd1, 64'h3, 64'h0, 1'b0, 64'h0, "R8 read esid 3");
        run(3'd2, 64'h3, 64'h0, 1'b0, 64'h0, "R8 read vsid 3");

        // R7 1TB disabled then enabled
        run(3'd0, 64'h0000_0500_0800_0007, 64'h4000_0000_1234_5100, 1'b0, 64'h0, "R7 1T disabled");
        cfg_ena_1t = 1'b1;
        run(3'd0, 64'h0000_0500_0800_0007, 64'h4000_0000_1234_5100, 1'b0, 64'h0, "R5 write 1T slot7");
        lookup(64'h0000_05AB_CDEF_0123, "R3 hit 1T");

        // R4 priority
        run(3'd0, 64'h0000_0012_3800_0009, 64'h0000_0000_0999_9000, 1'b0, 64'h0, "R5 write slot9 dup");
        lookup(64'h0000_0012_3000_0000, "R4 lowest of 3,9");
        run(3'd0, 64'h0000_0000_0800_0001, 64'h4000_0000_0077_7000, 1'b0, 64'h0, "R5 write 1T slot1");
        lookup(64'h0000_0012_3456_7890, "R4 1T slot1 first");

        // R6 / R7 / R8 / R12 errors
        run(3'd0, 64'h0000_0033_3800_0020, 64'h0, 1'b0, 64'h0, "R6 slot out of range");
        lookup(64'h0000_0033_3000_0000, "R6 oob write no entry");
        run(3'd0, 64'h0000_0044_3800_1002, 64'h0, 1'b0, 64'h0, "R6 reserved bit 12");
        run(3'd0, 64'h0000_0044_3800_0002, 64'h8000_0000_0000_0000, 1'b0, 64'h0, "R6 bad size");
        run(3'd0, 64'h0000_0044_3800_0002, 64'h0000_0000_0000_0010, 1'b0, 64'h0, "R7 bad page size");
        run(3'd1, 64'h2, 64'h0, 1'b0, 64'h0, "R6 slot2 untouched");
        run(3'd2, 64'h28, 64'h0, 1'b0, 64'h0, "R8 read oob");
        run(3'd7, 64'h3, 64'h0, 1'b0, 64'h0, "R12 bad op");
        run(3'd2, 64'h3, 64'h0, 1'b0, 64'h0, "R12 slot3 intact");

        // R9 find
        run(3'd0, 64'h0000_0000_3800_0004, 64'h0000_0000_0444_4000, 1'b0, 64'h0, "R5 write slot4");
        run(3'd3, 64'h0000_05AB_CDEF_0123, 64'h0, 1'b0, 64'h0, "R9 find hit");
        run(3'd3, 64'hDEAD_0000_3123_4567, 64'h0, 1'b0, 64'h0, "R9 find miss ones");
        cfg_mode32 = 1'b1;
        run(3'd3, 64'hDEAD_0000_3123_4567, 64'h0, 1'b0, 64'h0, "R9 find mode32");
        cfg_mode32 = 1'b0;

        // R10 invalidate by address, with concurrent lookup (R13)
        run(3'd5, 64'h0000_0012_3456_7890, 64'h0, 1'b1, 64'h0000_0012_3456_7890, "R10 inv global");
        lookup(64'h0000_0012_3456_7890, "R10 next is slot3");
        run(3'd4, 64'h0000_0012_3456_7890, 64'h0, 1'b0, 64'h0, "R10 inv local");
        lookup(64'h0000_0012_3456_7890, "R10 next is slot9");
        run(3'd4, 64'h0000_0077_0000_0000, 64'h0, 1'b0, 64'h0, "R10 inv miss");

        // R13 write and lookup same cycle
        run(3'd0, 64'h0000_00AB_C800_000A, 64'h0000_0000_0AAA_A100, 1'b1, 64'h0000_00AB_C000_1000, "R13 write+lookup");
        lookup(64'h0000_00AB_C000_1000, "R13 after write");

        // R11 invalidate all
        run(3'd0, 64'h0000_0066_6800_0000, 64'h0000_0000_0600_0000, 1'b0, 64'h0, "R5 write slot0");
        run(3'd6, 64'h0, 64'h0, 1'b0, 64'h0, "R11 inv all");
        lookup(64'h0000_0066_6000_0000, "R11 entry0 kept");
        lookup(64'h0000_05AB_CDEF_0123, "R11 slot7 gone");
        run(3'd1, 64'h7, 64'h0, 1'b0, 64'h0, "R11 slot7 valid cleared");
        run(3'd6, 64'h0, 64'h0, 1'b0, 64'h0, "R11 inv all no flush");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule